// File: doc/BRIEF.md
# Threshold Trigger Decision Unit

The unit takes one candidate word per bunch crossing from each of six trigger sources, plus a forced-trigger strobe, and produces one 16-bit report word per crossing. The sources have fixed but different pipeline depths. The vertex veto word arrives first. The muon word follows 5 crossings later. The electron, two hadron and calorimeter-sum words, together with the forced strobe, arrive 11 crossings after the vertex word. Internal delay lines realign all inputs to the crossing of the calorimeter words.

Each aligned value is compared with programmable thresholds. The unit accepts a crossing when at least one physics channel fires, both vetoes pass, and no error is seen. A forced strobe accepts the crossing unconditionally. A 3-bit downscaling mode can also admit a lower-threshold trigger once every few normal triggers, separately for each selected channel. Threshold, mode and period registers are loaded through a write port that carries an address and data.

Top module: `trig_decision_unit`

## Requirements
- R1: The vertex word is delayed 11 crossings and the muon word 6 crossings, so both line up with the calorimeter words and the forced strobe of the same crossing. The report for that crossing is registered one clock after the calorimeter words are presented.
- R2: Word layouts. The vertex, electron and hadron words are id[15:10], err[9:8], value[7:0]. The calorimeter-sum word is id[15:10], energy[9:0]. The muon word is id[15:10], err[9:8], charge[7] (ignored), pt[6:0].
- R3: Report bit 1 is set when electron ≥ its threshold, bit 3 when first hadron ≥ the single-hadron threshold, and bit 7 when muon pt ≥ its threshold (unsigned compares).
- R4: Report bit 5 is set only when the first hadron ≥ the first pair threshold and the second hadron ≥ the second pair threshold.
- R5: A veto passes when the vertex multiplicity ≤ its threshold and the calorimeter-sum energy ≤ its threshold. When either veto fails, the decision is 0 while the channel bits still show their hits.
- R6: Report bit 13 (sync error) is set when any aligned crossing ID differs from the vertex ID. While it is set, no non-forced accept occurs.
- R7: Report bit 14 (data error) is set when any 2-bit error field is nonzero. While it is set, no non-forced accept occurs.
- R8: Report bit 9 mirrors the aligned forced strobe. A forced crossing is always accepted.
- R9: Report bit 0 (decision) = forced OR (vetoes pass AND no error AND any normal or downscaled flag). Decision_o equals report bit 0.
- R10: Downscaling mode selects channels by a mask. Mode 0 selects none. Modes 1, 2 and 5 select electron only. Modes 3 and 6 select muon only. Modes 4 and 7 select electron, hadron, two-hadron and muon. A channel outside the mask never sets its downscaled bit and its counter does not advance.
- R11: For each channel in the mask, a counter counts qualified normal triggers. When the count reaches the period P, the channel is armed. The next qualified crossing that meets the low threshold but not the normal threshold sets the downscaled bit (electron 2, hadron 4, two-hadron 6, muon 8) and disarms the channel.
- R12: Register map by address. 0 electron threshold. 1 hadron threshold. 2 and 3 first and second pair thresholds. 4 muon threshold. 5 vertex threshold. 6 calorimeter-sum threshold. 7 to 11 low thresholds in the same channel order. 12 mode. 13 period. Reset sets all thresholds to all-ones, mode to 0 and period to 1, and clears the report. Report bits 10, 11, 12 and 15 are always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Crossing-rate clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| vtx_i | input | 16 | Vertex veto word (earliest) |
| ele_i | input | 16 | Electron word |
| had1_i | input | 16 | First hadron word |
| had2_i | input | 16 | Second hadron word |
| esum_i | input | 16 | Calorimeter-sum veto word |
| mu_i | input | 16 | Muon word |
| force_i | input | 1 | Forced-trigger strobe, timed with the calorimeter words |
| cfg_we_i | input | 1 | Register write enable |
| cfg_addr_i | input | 4 | Register address |
| cfg_data_i | input | 10 | Register write data |
| report_o | output | 16 | Per-crossing report word |
| decision_o | output | 1 | Accept decision |

## Verification
The hardest state to reach is an armed downscale channel that then meets a low-only crossing. To get there, the channel must first collect exactly P qualified normal triggers under a mode that selects it, with every input stream kept aligned across the delay lines. The bench streams one event per clock through a ring that drives each source at its own offset, and fills the gaps with neutral events. It then sends a low-only event before arming, P normal events, and two low-only events. Only the first low-only event after arming may produce the downscaled flag. A mode that excludes the channel is then shown to block the same sequence.

// File: rtl/tdu_pkg.sv
package tdu_pkg;
  localparam int WORD_W = 16;
  localparam int ID_W   = 6;
  localparam int NCH    = 4;   // 0 ele, 1 had, 2 two-had, 3 mu
  localparam int PER_W  = 8;
  localparam int CFG_AW = 4;
  localparam int CFG_DW = 10;
  localparam int CALO_LAT = 11; // calo words behind vertex
  localparam int MU_LAT   = 5;  // muon word behind vertex

  typedef struct packed {
    logic [7:0]       ele_thr;
    logic [7:0]       had_thr;
    logic [7:0]       h2a_thr;
    logic [7:0]       h2b_thr;
    logic [6:0]       mu_thr;
    logic [7:0]       vtx_thr;
    logic [9:0]       esum_thr;
    logic [7:0]       ele_lo;
    logic [7:0]       had_lo;
    logic [7:0]       h2a_lo;
    logic [7:0]       h2b_lo;
    logic [6:0]       mu_lo;
    logic [2:0]       mode;
    logic [PER_W-1:0] period;
  } cfg_t;

  localparam cfg_t CFG_RST = '{
    ele_thr: '1, had_thr: '1, h2a_thr: '1, h2b_thr: '1, mu_thr: '1,
    vtx_thr: '1, esum_thr: '1, ele_lo: '1, had_lo: '1, h2a_lo: '1,
    h2b_lo: '1, mu_lo: '1, mode: '0, period: PER_W'(1)};

  function automatic logic [NCH-1:0] ds_mask(input logic [2:0] mode);
    case (mode)
      3'd1, 3'd2, 3'd5: ds_mask = 4'b0001;
      3'd3, 3'd6:       ds_mask = 4'b1000;
      3'd4, 3'd7:       ds_mask = 4'b1111;
      default:          ds_mask = 4'b0000;
    endcase
  endfunction
endpackage

// File: rtl/tdu_delay.sv
module tdu_delay #(
  parameter int W = 16,
  parameter int D = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  generate
    if (D == 0) begin : g_wire
      assign q_o = d_i;
    end else begin : g_pipe
      logic [W-1:0] pipe [D];
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          for (int i = 0; i < D; i++) pipe[i] <= '0;
        end else begin
          pipe[0] <= d_i;
          for (int i = 1; i < D; i++) pipe[i] <= pipe[i-1];
        end
      end
      assign q_o = pipe[D-1];
    end
  endgenerate
endmodule

// File: rtl/tdu_cfg.sv
module tdu_cfg
  import tdu_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [CFG_AW-1:0] addr_i,
  input  logic [CFG_DW-1:0] data_i,
  output cfg_t              cfg_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_o <= CFG_RST;
    end else if (we_i) begin
      case (addr_i)
        4'd0:  cfg_o.ele_thr  <= data_i[7:0];
        4'd1:  cfg_o.had_thr  <= data_i[7:0];
        4'd2:  cfg_o.h2a_thr  <= data_i[7:0];
        4'd3:  cfg_o.h2b_thr  <= data_i[7:0];
        4'd4:  cfg_o.mu_thr   <= data_i[6:0];
        4'd5:  cfg_o.vtx_thr  <= data_i[7:0];
        4'd6:  cfg_o.esum_thr <= data_i[9:0];
        4'd7:  cfg_o.ele_lo   <= data_i[7:0];
        4'd8:  cfg_o.had_lo   <= data_i[7:0];
        4'd9:  cfg_o.h2a_lo   <= data_i[7:0];
        4'd10: cfg_o.h2b_lo   <= data_i[7:0];
        4'd11: cfg_o.mu_lo    <= data_i[6:0];
        4'd12: cfg_o.mode     <= data_i[2:0];
        4'd13: cfg_o.period   <= data_i[PER_W-1:0];
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/tdu_prescale.sv
module tdu_prescale
  import tdu_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             qual_i,
  input  logic             norm_i,
  input  logic             low_i,
  input  logic [PER_W-1:0] period_i,
  output logic             ds_o
);
  logic [PER_W-1:0] cnt_q;
  logic             armed_q;
  logic             step;
  logic             wrap;

  assign step = en_i && qual_i;
  assign ds_o = step && armed_q && low_i && !norm_i;
  assign wrap = ({1'b0, cnt_q} + 1'b1) >= {1'b0, period_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else if (ds_o) begin
      armed_q <= 1'b0;
    end else if (step && !armed_q && norm_i) begin
      if (wrap) begin
        cnt_q   <= '0;
        armed_q <= 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/trig_decision_unit.sv
module trig_decision_unit
  import tdu_pkg::*;
#(
  parameter int VTX_DLY = CALO_LAT,
  parameter int MU_DLY  = CALO_LAT - MU_LAT
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [WORD_W-1:0] vtx_i,
  input  logic [WORD_W-1:0] ele_i,
  input  logic [WORD_W-1:0] had1_i,
  input  logic [WORD_W-1:0] had2_i,
  input  logic [WORD_W-1:0] esum_i,
  input  logic [WORD_W-1:0] mu_i,
  input  logic              force_i,
  input  logic              cfg_we_i,
  input  logic [CFG_AW-1:0] cfg_addr_i,
  input  logic [CFG_DW-1:0] cfg_data_i,
  output logic [WORD_W-1:0] report_o,
  output logic              decision_o
);
  localparam int MU_W = WORD_W - 1; // charge bit dropped

  cfg_t              cfg;
  logic [WORD_W-1:0] vtx_a;
  logic [MU_W-1:0]   mu_a;
  logic              unused_charge;

  assign unused_charge = mu_i[7];

  tdu_cfg i_cfg (
    .clk_i, .rst_ni, .we_i(cfg_we_i), .addr_i(cfg_addr_i),
    .data_i(cfg_data_i), .cfg_o(cfg)
  );

  tdu_delay #(.W(WORD_W), .D(VTX_DLY)) i_vtx_dly (
    .clk_i, .rst_ni, .d_i(vtx_i), .q_o(vtx_a)
  );

  tdu_delay #(.W(MU_W), .D(MU_DLY)) i_mu_dly (
    .clk_i, .rst_ni, .d_i({mu_i[15:8], mu_i[6:0]}), .q_o(mu_a)
  );

  // aligned fields
  logic [ID_W-1:0] id_ref;
  logic [7:0]      v_mult, e_et, h1_et, h2_et;
  logic [9:0]      s_et;
  logic [6:0]      m_pt;
  logic            sync_err, data_err, veto_ok, qual;
  logic [NCH-1:0]  norm, low, ds, mask;
  logic            decision;
  logic [WORD_W-1:0] rep_d;

  assign id_ref = vtx_a[15:10];
  assign v_mult = vtx_a[7:0];
  assign e_et   = ele_i[7:0];
  assign h1_et  = had1_i[7:0];
  assign h2_et  = had2_i[7:0];
  assign s_et   = esum_i[9:0];
  assign m_pt   = mu_a[6:0];

  assign sync_err = (ele_i[15:10]  != id_ref) || (had1_i[15:10] != id_ref) ||
                    (had2_i[15:10] != id_ref) || (esum_i[15:10] != id_ref) ||
                    (mu_a[14:9]    != id_ref);
  assign data_err = |{vtx_a[9:8], ele_i[9:8], had1_i[9:8], had2_i[9:8], mu_a[8:7]};
  assign veto_ok  = (v_mult <= cfg.vtx_thr) && (s_et <= cfg.esum_thr);
  assign qual     = veto_ok && !sync_err && !data_err;

  assign norm[0] = e_et  >= cfg.ele_thr;
  assign norm[1] = h1_et >= cfg.had_thr;
  assign norm[2] = (h1_et >= cfg.h2a_thr) && (h2_et >= cfg.h2b_thr);
  assign norm[3] = m_pt  >= cfg.mu_thr;
  assign low[0]  = e_et  >= cfg.ele_lo;
  assign low[1]  = h1_et >= cfg.had_lo;
  assign low[2]  = (h1_et >= cfg.h2a_lo) && (h2_et >= cfg.h2b_lo);
  assign low[3]  = m_pt  >= cfg.mu_lo;
  assign mask    = ds_mask(cfg.mode);

  for (genvar k = 0; k < NCH; k++) begin : g_ch
    tdu_prescale i_ps (
      .clk_i, .rst_ni, .en_i(mask[k]), .qual_i(qual), .norm_i(norm[k]),
      .low_i(low[k]), .period_i(cfg.period), .ds_o(ds[k])
    );
    assign rep_d[1+2*k] = norm[k];
    assign rep_d[2+2*k] = ds[k];
  end

  assign decision = force_i || (qual && (|norm || |ds));

  assign rep_d[0]     = decision;
  assign rep_d[9]     = force_i;
  assign rep_d[12:10] = '0;
  assign rep_d[13]    = sync_err;
  assign rep_d[14]    = data_err;
  assign rep_d[15]    = 1'b0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) report_o <= '0;
    else         report_o <= rep_d;
  end

  assign decision_o = report_o[0];
endmodule

// File: rtl/tdu_checker.sv
module tdu_checker (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [15:0] report_o,
  input logic        decision_o
);
  // R6, R7: errors block non-forced accepts
  p_err_blocks_r6_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((report_o[13] || report_o[14]) && !report_o[9]) |-> !report_o[0]);

  // R11: a downscaled flag always comes with an accept
  p_ds_accepts_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (report_o[2] || report_o[4] || report_o[6] || report_o[8]) |-> report_o[0]);

  // R11: downscaled and normal flags of a channel are exclusive
  p_ds_low_only_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !((report_o[1] && report_o[2]) || (report_o[3] && report_o[4]) ||
      (report_o[5] && report_o[6]) || (report_o[7] && report_o[8])));

  // R9: an accept has a cause
  p_accept_cause_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    report_o[0] |-> (report_o[9] || (|report_o[8:1])));

  // R8: forced always accepted
  p_forced_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    report_o[9] |-> decision_o);

  // R12: reserved bits stay zero
  p_reserved_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (report_o[12:10] == 3'b000) && !report_o[15]);
endmodule

bind trig_decision_unit tdu_checker i_tdu_checker (
  .clk_i(clk_i), .rst_ni(rst_ni), .report_o(report_o), .decision_o(decision_o)
);

// File: tb/test_trig_decision_unit.sv
module test_trig_decision_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] vtx_i = '0, ele_i = '0, had1_i = '0, had2_i = '0, esum_i = '0, mu_i = '0;
  logic        force_i = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [3:0]  cfg_addr_i = '0;
  logic [9:0]  cfg_data_i = '0;
  logic [15:0] report_o;
  logic        decision_o;

  int total = 0;
  int bad = 0;
  int c = 0;
  bit done = 0;

  logic [15:0] r_vtx [256];
  logic [15:0] r_ele [256];
  logic [15:0] r_h1  [256];
  logic [15:0] r_h2  [256];
  logic [15:0] r_es  [256];
  logic [15:0] r_mu  [256];
  logic        r_f   [256];
  logic [15:0] rep_at [256];

  trig_decision_unit i_trig_decision_unit (
    .clk_i(clk), .rst_ni, .vtx_i, .ele_i, .had1_i, .had2_i, .esum_i, .mu_i,
    .force_i, .cfg_we_i, .cfg_addr_i, .cfg_data_i, .report_o, .decision_o
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      bad++;
      $display("FAIL watchdog: run hung, got timeout expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // one crossing: each source driven at its own offset
  task automatic step();
    @(negedge clk);
    vtx_i   = r_vtx[c & 255];
    mu_i    = r_mu[(c - 5) & 255];
    ele_i   = r_ele[(c - 11) & 255];
    had1_i  = r_h1[(c - 11) & 255];
    had2_i  = r_h2[(c - 11) & 255];
    esum_i  = r_es[(c - 11) & 255];
    force_i = r_f[(c - 11) & 255];
    @(posedge clk);
    #1;
    rep_at[(c - 11) & 255] = report_o;
    c++;
  endtask

  task automatic send(input int ele, input int h1, input int h2, input int mu,
                      input int vm, input int es, input logic [1:0] eerr,
                      input int mu_off, input logic f);
    int i;
    logic [5:0] id;
    logic [5:0] mid;
    i   = c & 255;
    id  = 6'(c);
    mid = 6'(c + mu_off);
    r_vtx[i] = {id, 2'b00, 8'(vm)};
    r_ele[i] = {id, eerr, 8'(ele)};
    r_h1[i]  = {id, 2'b00, 8'(h1)};
    r_h2[i]  = {id, 2'b00, 8'(h2)};
    r_es[i]  = {id, 10'(es)};
    r_mu[i]  = {mid, 2'b00, 1'b1, 7'(mu)}; // charge set, must be ignored (R2)
    r_f[i]   = f;
    step();
  endtask

  task automatic filler();
    send(0, 0, 0, 0, 0, 0, 2'b00, 0, 1'b0);
  endtask

  task automatic run_ev(input int ele, input int h1, input int h2, input int mu,
                        input int vm, input int es, input logic [1:0] eerr,
                        input int mu_off, input logic f, output logic [15:0] rep);
    int idx;
    idx = c;
    send(ele, h1, h2, mu, vm, es, eerr, mu_off, f);
    repeat (11) filler();
    rep = rep_at[idx & 255];
  endtask

  task automatic wr(input int a, input int d);
    cfg_we_i   = 1'b1;
    cfg_addr_i = 4'(a);
    cfg_data_i = 10'(d);
    filler();
    cfg_we_i   = 1'b0;
  endtask

  task automatic t_reset();
    #(CLK_PERIOD * 3);
    chk("R12 reset report", report_o, 16'h0000);
    chk("R12 reset decision", {15'd0, decision_o}, 16'h0000);
  endtask

  task automatic t_config();
    wr(0, 100); wr(1, 100); wr(2, 50); wr(3, 30); wr(4, 64);
    wr(5, 20);  wr(6, 500); wr(7, 50); wr(8, 60); wr(9, 20);
    wr(10, 10); wr(11, 32); wr(13, 3); wr(12, 0);
    repeat (12) filler();
  endtask

  task automatic t_channels();
    logic [15:0] r;
    run_ev(120, 0, 0, 0, 0, 0, 2'b00, 0, 1'b0, r);
    chk("R1 R3 electron aligned", r, 16'h0003);
    run_ev(0, 150, 0, 0, 0, 0, 2'b00, 0, 1'b0, r);
    chk("R3 one hadron", r, 16'h0009);
    run_ev(0, 0, 0, 70, 0, 0, 2'b00, 0, 1'b0, r);
    chk("R2 R3 muon pt charge ignored", r, 16'h0081);
  endtask

  task automatic t_two_had();
    logic [15:0] r;
    run_ev(0, 60, 40, 0, 0, 0, 2'b00, 0, 1'b0, r);
    chk("R4 two hadrons both pass", r, 16'h0021);
    run_ev(0, 60, 20, 0, 0, 0, 2'b00, 0, 1'b0, r);
    chk("R4 second hadron low", r, 16'h0000);
  endtask

  task automatic t_veto();
    logic [15:0] r;
    run_ev(120, 0, 0, 0, 21, 0, 2'b00, 0, 1'b0, r);
    chk("R5 vertex veto blocks", r, 16'h0002);
    run_ev(120, 0, 0, 0, 20, 500, 2'b00, 0, 1'b0, r);
    chk("R5 veto at threshold passes", r, 16'h0003);
    run_ev(120, 0, 0, 0, 0, 501, 2'b00, 0, 1'b0, r);
    chk("R5 calo sum veto blocks", r, 16'h0002);
  endtask

  task automatic t_errors();
    logic [15:0] r;
    run_ev(120, 0, 0, 0, 0, 0, 2'b00, 1, 1'b0, r);
    chk("R6 sync error", r, 16'h2002);
    run_ev(120, 0, 0, 0, 0, 0, 2'b01, 0, 1'b0, r);
    chk("R7 data error", r, 16'h4002);
    run_ev(0, 0, 0, 0, 0, 0, 2'b00, 0, 1'b1, r);
    chk("R8 R9 forced", r, 16'h0201);
  endtask

  task automatic t_downscale_ele();
    logic [15:0] r;
    wr(12, 1);
    run_ev(60, 0, 0, 0, 0, 0, 2'b00, 0, 1'b0, r);
    chk("R11 low before arming", r, 16'h0000);
    for (int n = 0; n < 3; n++) begin
      run_ev(120, 0, 0, 0, 0, 0, 2'b00, 0, 1'b0, r);
      chk("R11 normal electron counted", r, 16'h0003);
    end
    run_ev(60, 0, 0, 0, 0, 0, 2'b00, 0, 1'b0, r);
    chk("R11 R9 downscaled electron", r, 16'h0005);
    run_ev(60, 0, 0, 0, 0, 0, 2'b00, 0, 1'b0, r);
    chk("R11 credit consumed", r, 16'h0000);
  endtask

  task automatic t_downscale_mu();
    logic [15:0] r;
    wr(12, 3);
    for (int n = 0; n < 3; n++) begin
      run_ev(120, 0, 0, 70, 0, 0, 2'b00, 0, 1'b0, r);
      chk("R10 normal ele and mu", r, 16'h0083);
    end
    run_ev(60, 0, 0, 0, 0, 0, 2'b00, 0, 1'b0, r);
    chk("R10 electron excluded in mode 3", r, 16'h0000);
    run_ev(0, 0, 0, 40, 0, 0, 2'b00, 0, 1'b0, r);
    chk("R10 R11 downscaled muon", r, 16'h0101);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin
      r_vtx[i] = {6'(i), 10'd0}; r_ele[i] = {6'(i), 10'd0};
      r_h1[i]  = {6'(i), 10'd0}; r_h2[i]  = {6'(i), 10'd0};
      r_es[i]  = {6'(i), 10'd0}; r_mu[i]  = {6'(i), 10'd0};
      r_f[i]   = 1'b0;           rep_at[i] = '0;
    end
    t_reset();
    @(negedge clk);
    rst_ni = 1'b1;
    repeat (14) filler();
    t_config();
    t_channels();
    t_two_had();
    t_veto();
    t_errors();
    t_downscale_ele();
    t_downscale_mu();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule